// File: doc/BRIEF.md
# Integer Multiply-Divide Issue Scheduler

This block sits behind the decode stage of an integer core. Each cycle it may receive one decoded instruction: a class tag, a two-bit function code, two 32-bit operands and a destination tag. It sends the instruction to one of two independent execution units. The first is a single-cycle arithmetic/bit-field unit. The second is a multiply/divide unit, which combines a three-stage pipelined multiplier with a 32-step restoring divider. Each unit returns its result with the destination tag on its own result port.

A structural conflict arises when a multiply follows a divide, or when a divide follows a multiply or another divide. In that case the block raises a combinational stall toward the front end. The front end holds the instruction on its inputs until the stall drops. Multiplies overlap with each other. Arithmetic instructions are never held back by the divider.

Top module: `imd_issue_sched`

## Requirements
- R1: An accepted arithmetic-class instruction (class 0) appears on the arithmetic result port in the next cycle, with its destination tag. One such instruction can be accepted every cycle. The function codes are: 0 gives a+b, 1 gives a-b, 2 gives a AND b, and 3 rotates a left by b[4:0].
- R2: An accepted multiply (class 1) appears on the multiply/divide port three cycles after its issue cycle, carrying the low 32 bits of a*b. Multiplies can issue in consecutive cycles. The function code has no effect on a multiply.
- R3: An accepted divide (class 2) appears on the multiply/divide port 33 cycles after its issue cycle. Function bit 0 selects signed operation. Function bit 1 selects the remainder instead of the quotient. The quotient truncates toward zero, and the remainder takes the sign of the dividend.
- R4: A divide by zero returns all ones as the quotient and the dividend as the remainder, and raises no error.
- R5: A valid multiply raises the stall in every cycle from the one after a divide issues up to, but not including, the cycle in which that divide's result appears.
- R6: A valid divide raises the stall while a divide is in progress (the same window as R5). It also raises the stall in the two cycles that follow a multiply issue.
- R7: An arithmetic-class instruction never raises the stall, including in the cycles directly before, during and after a divide.
- R8: The arithmetic port and the multiply/divide port can both deliver a result in the same cycle. Each port keeps its own valid flag and tag.
- R9: While the stall is high, or while in_valid is low, the inputs are ignored: no result is later produced for them. The stall is low whenever in_valid is low.
- R10: During reset and right after it, both result valids and the stall are low.
- R11: Class 3 is a no-operation. It is accepted without a stall and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_class | input | 2 | 0 arithmetic, 1 multiply, 2 divide, 3 no-op |
| in_func | input | 2 | Function code (see R1, R3) |
| in_opa | input | 32 | First operand / dividend |
| in_opb | input | 32 | Second operand / divisor |
| in_dst | input | 5 | Destination tag |
| stall | output | 1 | Presented instruction not taken; hold it |
| alu_vld | output | 1 | Arithmetic result valid |
| alu_data | output | 32 | Arithmetic result |
| alu_dst | output | 5 | Arithmetic result tag |
| md_vld | output | 1 | Multiply/divide result valid |
| md_data | output | 32 | Multiply/divide result |
| md_dst | output | 5 | Multiply/divide result tag |

## Verification
Two completions can land in the same cycle. One is an arithmetic result. The other is a multiply or divide result that was issued earlier. To provoke this, the stimulus issues two multiplies and then two arithmetic instructions, and it streams arithmetic instructions across a divide's issue cycle, its iterations and its completion cycle. The bench model keeps a queue of pending multiply/divide results keyed by due cycle, and tracks the arithmetic result separately. Every cycle it checks both ports and the stall against that queue and that separate record.

// File: rtl/imd_pkg.sv
package imd_pkg;

  parameter int unsigned IMD_DW = 32;
  localparam int unsigned IMD_HW = IMD_DW / 2;
  localparam int unsigned IMD_SW = $clog2(IMD_DW);

  typedef enum logic [1:0] {
    CLS_ALU = 2'd0,
    CLS_MUL = 2'd1,
    CLS_DIV = 2'd2,
    CLS_NOP = 2'd3
  } imd_cls_e;

  typedef struct packed {
    logic [IMD_DW-1:0] rem;
    logic [IMD_DW-1:0] quo;
  } div_st_t;

  // arithmetic / bit-field result
  function automatic logic [IMD_DW-1:0] alu_eval(input logic [1:0] fn,
                                                 input logic [IMD_DW-1:0] a,
                                                 input logic [IMD_DW-1:0] b);
    logic [2*IMD_DW-1:0] dbl;
    logic [IMD_DW-1:0]   r;
    dbl = {a, a} << b[IMD_SW-1:0];
    case (fn)
      2'd0:    r = a + b;
      2'd1:    r = a - b;
      2'd2:    r = a & b;
      default: r = dbl[2*IMD_DW-1:IMD_DW];
    endcase
    return r;
  endfunction

  // low half of a times all of b, truncated
  function automatic logic [IMD_DW-1:0] mul_part_lo(input logic [IMD_DW-1:0] a,
                                                    input logic [IMD_DW-1:0] b);
    return {{IMD_HW{1'b0}}, a[IMD_HW-1:0]} * b;
  endfunction

  // high half of a times low half of b, shifted into place
  function automatic logic [IMD_DW-1:0] mul_part_hi(input logic [IMD_DW-1:0] a,
                                                    input logic [IMD_DW-1:0] b);
    logic [IMD_DW-1:0] p;
    p = {{IMD_HW{1'b0}}, a[IMD_DW-1:IMD_HW]} * {{IMD_HW{1'b0}}, b[IMD_HW-1:0]};
    return p << IMD_HW;
  endfunction

  function automatic logic [IMD_DW-1:0] cond_neg(input logic [IMD_DW-1:0] v,
                                                 input logic n);
    return n ? (~v + 1'b1) : v;
  endfunction

  // one restoring step: shift in next dividend bit, try subtract
  function automatic div_st_t div_step(input logic [IMD_DW-1:0] rem,
                                       input logic [IMD_DW-1:0] quo,
                                       input logic [IMD_DW-1:0] dvsr);
    div_st_t        r;
    logic [IMD_DW:0] sh;
    logic [IMD_DW:0] df;
    sh = {rem, quo[IMD_DW-1]};
    df = sh - {1'b0, dvsr};
    if (!df[IMD_DW]) begin
      r.rem = df[IMD_DW-1:0];
      r.quo = {quo[IMD_DW-2:0], 1'b1};
    end else begin
      r.rem = sh[IMD_DW-1:0];
      r.quo = {quo[IMD_DW-2:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/imd_issue_ctl.sv
module imd_issue_ctl (
  input  logic       in_valid,
  input  logic [1:0] in_class,
  input  logic       mul_busy,
  input  logic       div_busy,
  output logic       stall,
  output logic       alu_issue,
  output logic       mul_issue,
  output logic       div_issue
);
  import imd_pkg::*;

  imd_cls_e cls;
  logic     hold_mul;
  logic     hold_div;
  logic     take;

  assign cls      = imd_cls_e'(in_class);
  assign hold_mul = (cls == CLS_MUL) && div_busy;
  assign hold_div = (cls == CLS_DIV) && (div_busy || mul_busy);
  assign stall    = in_valid && (hold_mul || hold_div);
  assign take     = in_valid && !stall;

  assign alu_issue = take && (cls == CLS_ALU);
  assign mul_issue = take && (cls == CLS_MUL);
  assign div_issue = take && (cls == CLS_DIV);
endmodule

// File: rtl/imd_alu_unit.sv
module imd_alu_unit #(
  parameter int unsigned DW = 32,
  parameter int unsigned TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [1:0]    fn,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [TW-1:0] dst,
  output logic          done,
  output logic [DW-1:0] res,
  output logic [TW-1:0] res_dst
);
  import imd_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      res     <= '0;
      res_dst <= '0;
    end else begin
      done <= issue;
      if (issue) begin
        res     <= alu_eval(fn, a, b);
        res_dst <= dst;
      end
    end
  end
endmodule

// File: rtl/imd_mul_pipe.sv
module imd_mul_pipe #(
  parameter int unsigned DW = 32,
  parameter int unsigned TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [TW-1:0] dst,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] res,
  output logic [TW-1:0] res_dst
);
  import imd_pkg::*;

  logic          v1, v2;
  logic [DW-1:0] a1, b1;
  logic [DW-1:0] p_lo, p_hi;
  logic [TW-1:0] d1, d2;

  assign busy = v1 || v2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; done <= 1'b0;
      a1 <= '0; b1 <= '0; p_lo <= '0; p_hi <= '0;
      d1 <= '0; d2 <= '0; res <= '0; res_dst <= '0;
    end else begin
      v1   <= issue;
      v2   <= v1;
      done <= v2;
      if (issue) begin
        a1 <= a;
        b1 <= b;
        d1 <= dst;
      end
      if (v1) begin
        p_lo <= mul_part_lo(a1, b1);
        p_hi <= mul_part_hi(a1, b1);
        d2   <= d1;
      end
      if (v2) begin
        res     <= p_lo + p_hi;
        res_dst <= d2;
      end
    end
  end
endmodule

// File: rtl/imd_div_iter.sv
module imd_div_iter #(
  parameter int unsigned DW = 32,
  parameter int unsigned TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          sgn,
  input  logic          want_rem,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [TW-1:0] dst,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] res,
  output logic [TW-1:0] res_dst
);
  import imd_pkg::*;

  localparam int unsigned CW = $clog2(DW) + 1;

  logic          run;
  logic [CW-1:0] cnt;
  logic [DW-1:0] rem, quo, dvsr;
  logic          neg_q, neg_r, w_rem, dz;
  logic [TW-1:0] dst_r;
  div_st_t       nxt;
  logic [DW-1:0] q_fin, r_fin;
  logic          last;

  assign busy = run;
  assign last = (cnt == CW'(1));

  always_comb begin
    nxt   = div_step(rem, quo, dvsr);
    q_fin = dz ? '1 : cond_neg(nxt.quo, neg_q);
    r_fin = cond_neg(nxt.rem, neg_r);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; cnt <= '0; rem <= '0; quo <= '0; dvsr <= '0;
      neg_q <= 1'b0; neg_r <= 1'b0; w_rem <= 1'b0; dz <= 1'b0;
      dst_r <= '0; done <= 1'b0; res <= '0; res_dst <= '0;
    end else begin
      done <= 1'b0;
      if (issue) begin
        run   <= 1'b1;
        cnt   <= CW'(DW);
        rem   <= '0;
        quo   <= cond_neg(a, sgn && a[DW-1]);
        dvsr  <= cond_neg(b, sgn && b[DW-1]);
        neg_q <= sgn && (a[DW-1] ^ b[DW-1]) && (b != '0);
        neg_r <= sgn && a[DW-1];
        dz    <= (b == '0);
        w_rem <= want_rem;
        dst_r <= dst;
      end else if (run) begin
        rem <= nxt.rem;
        quo <= nxt.quo;
        cnt <= cnt - 1'b1;
        if (last) begin
          run     <= 1'b0;
          done    <= 1'b1;
          res     <= w_rem ? r_fin : q_fin;
          res_dst <= dst_r;
        end
      end
    end
  end
endmodule

// File: rtl/imd_issue_sched.sv
module imd_issue_sched #(
  parameter int unsigned TW = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [1:0]                 in_class,
  input  logic [1:0]                 in_func,
  input  logic [imd_pkg::IMD_DW-1:0] in_opa,
  input  logic [imd_pkg::IMD_DW-1:0] in_opb,
  input  logic [TW-1:0]              in_dst,
  output logic                       stall,
  output logic                       alu_vld,
  output logic [imd_pkg::IMD_DW-1:0] alu_data,
  output logic [TW-1:0]              alu_dst,
  output logic                       md_vld,
  output logic [imd_pkg::IMD_DW-1:0] md_data,
  output logic [TW-1:0]              md_dst
);
  localparam int unsigned DW = imd_pkg::IMD_DW;

  // named internal events (observed by the bound checker)
  logic          alu_issue, mul_issue, div_issue;
  logic          mul_busy, div_busy;
  logic          mul_done, div_done;
  logic [DW-1:0] mul_res, div_res;
  logic [TW-1:0] mul_dst, div_dst;

  imd_issue_ctl u_ctl (
    .in_valid (in_valid),
    .in_class (in_class),
    .mul_busy (mul_busy),
    .div_busy (div_busy),
    .stall    (stall),
    .alu_issue(alu_issue),
    .mul_issue(mul_issue),
    .div_issue(div_issue)
  );

  imd_alu_unit #(.DW(DW), .TW(TW)) u_alu (
    .clk(clk), .rst_n(rst_n), .issue(alu_issue), .fn(in_func),
    .a(in_opa), .b(in_opb), .dst(in_dst),
    .done(alu_vld), .res(alu_data), .res_dst(alu_dst)
  );

  imd_mul_pipe #(.DW(DW), .TW(TW)) u_mul (
    .clk(clk), .rst_n(rst_n), .issue(mul_issue),
    .a(in_opa), .b(in_opb), .dst(in_dst),
    .busy(mul_busy), .done(mul_done), .res(mul_res), .res_dst(mul_dst)
  );

  imd_div_iter #(.DW(DW), .TW(TW)) u_div (
    .clk(clk), .rst_n(rst_n), .issue(div_issue),
    .sgn(in_func[0]), .want_rem(in_func[1]),
    .a(in_opa), .b(in_opb), .dst(in_dst),
    .busy(div_busy), .done(div_done), .res(div_res), .res_dst(div_dst)
  );

  assign md_vld  = mul_done || div_done;
  assign md_data = div_done ? div_res : mul_res;
  assign md_dst  = div_done ? div_dst : mul_dst;
endmodule

// File: rtl/imd_issue_sched_chk.sv
module imd_issue_sched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [1:0] in_class,
  input logic       stall,
  input logic       alu_issue,
  input logic       mul_issue,
  input logic       div_issue,
  input logic       mul_busy,
  input logic       div_busy,
  input logic       mul_done,
  input logic       div_done,
  input logic       alu_vld,
  input logic       md_vld
);
  a_r1_alu_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    alu_issue |=> alu_vld);

  a_r2_mul_three_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    mul_issue |-> ##3 md_vld);

  a_r3_div_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    div_issue |=> div_busy);

  a_r5_mul_not_into_div: assert property (@(posedge clk) disable iff (!rst_n)
    mul_issue |-> !div_busy);

  a_r6_div_unit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    div_issue |-> !(div_busy || mul_busy));

  a_r7_alu_never_held: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 2'd0) |-> !stall);

  a_r8_single_md_source: assert property (@(posedge clk) disable iff (!rst_n)
    !(mul_done && div_done));

  a_r9_stall_blocks_issue: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !(alu_issue || mul_issue || div_issue));

  a_r9_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !stall);

  a_r11_nop_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 2'd3) |-> !stall);
endmodule

bind imd_issue_sched imd_issue_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
  .stall(stall), .alu_issue(alu_issue), .mul_issue(mul_issue),
  .div_issue(div_issue), .mul_busy(mul_busy), .div_busy(div_busy),
  .mul_done(mul_done), .div_done(div_done), .alu_vld(alu_vld),
  .md_vld(md_vld)
);

// File: tb/imd_issue_sched_tb_top.sv
`timescale 1ns/1ps
module imd_issue_sched_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_class, in_func;
  logic [31:0] in_opa, in_opb;
  logic [4:0]  in_dst;
  logic        stall, alu_vld, md_vld;
  logic [31:0] alu_data, md_data;
  logic [4:0]  alu_dst, md_dst;

  always #2.5 clk = ~clk;

  imd_issue_sched dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_func(in_func), .in_opa(in_opa), .in_opb(in_opb), .in_dst(in_dst),
    .stall(stall), .alu_vld(alu_vld), .alu_data(alu_data), .alu_dst(alu_dst),
    .md_vld(md_vld), .md_data(md_data), .md_dst(md_dst)
  );

  typedef struct { int cls; int fn; logic [31:0] a; logic [31:0] b; int dst; } ins_t;
  typedef struct { int due; logic [31:0] d; int dst; string rq; } exp_t;

  ins_t prog[$];
  exp_t mdq[$];
  int   cyc = 0, n_cmp = 0, n_bad = 0;
  bit   fin = 0;
  int   last_mul = -100, div_end = -100;
  logic        ealu_v = 1'b0;
  logic [31:0] ealu_d = '0;
  int          ealu_t = 0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: got %h expected %h", rq, cyc, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_alu(input int fn, input logic [31:0] a, input logic [31:0] b);
    int s;
    s = int'(b[4:0]);
    case (fn)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      default: return (a << s) | (a >> (32 - s));
    endcase
  endfunction

  function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] p;
    p = {32'd0, a} * {32'd0, b};
    return p[31:0];
  endfunction

  function automatic logic [31:0] ref_div(input int fn, input logic [31:0] a, input logic [31:0] b);
    longint x, y, q, r;
    if (b == 0) return fn[1] ? a : 32'hFFFF_FFFF;
    if (fn[0]) begin x = longint'($signed(a)); y = longint'($signed(b)); end
    else       begin x = longint'({32'd0, a}); y = longint'({32'd0, b}); end
    q = x / y;
    r = x % y;
    return fn[1] ? r[31:0] : q[31:0];
  endfunction

  task automatic add(input int cls, input int fn, input logic [31:0] a, input logic [31:0] b, input int dst);
    ins_t t;
    t.cls = cls; t.fn = fn; t.a = a; t.b = b; t.dst = dst;
    prog.push_back(t);
  endtask

  task automatic run_cycle();
    logic  v, est;
    ins_t  h;
    string srq;
    exp_t  e;
    @(negedge clk);
    v = (prog.size() > 0);
    if (v) h = prog[0];
    else begin h.cls = 2; h.fn = 0; h.a = 32'd9; h.b = 32'd3; h.dst = 31; end
    in_valid = v; in_class = 2'(h.cls); in_func = 2'(h.fn);
    in_opa = h.a; in_opb = h.b; in_dst = 5'(h.dst);
    #1;
    // expected stall from the model's unit state
    est = 1'b0;
    if (v && h.cls == 1 && cyc < div_end) est = 1'b1;
    if (v && h.cls == 2 && (cyc < div_end || cyc <= last_mul + 2)) est = 1'b1;
    if (!v) srq = "R9";
    else case (h.cls) 0: srq = "R7"; 1: srq = "R5"; 2: srq = "R6"; default: srq = "R11"; endcase
    chk(srq, {31'd0, stall}, {31'd0, est});
    // arithmetic port (R1), concurrent completions tagged R8
    chk((ealu_v && mdq.size() > 0 && mdq[0].due == cyc) ? "R8" : "R1", {31'd0, alu_vld}, {31'd0, ealu_v});
    if (ealu_v) begin
      chk("R1", alu_data, ealu_d);
      chk("R1", {27'd0, alu_dst}, 32'(ealu_t));
    end
    // multiply/divide port
    if (mdq.size() > 0 && mdq[0].due == cyc) begin
      e = mdq.pop_front();
      chk(e.rq, {31'd0, md_vld}, 32'd1);
      chk(e.rq, md_data, e.d);
      chk(e.rq, {27'd0, md_dst}, 32'(e.dst));
    end else chk("R9", {31'd0, md_vld}, 32'd0);
    // model acceptance
    ealu_v = 1'b0;
    if (v && !est) begin
      case (h.cls)
        0: begin ealu_v = 1'b1; ealu_d = ref_alu(h.fn, h.a, h.b); ealu_t = h.dst; end
        1: begin
          e.due = cyc + 3; e.d = ref_mul(h.a, h.b); e.dst = h.dst; e.rq = "R2";
          mdq.push_back(e); last_mul = cyc;
        end
        2: begin
          e.due = cyc + 33; e.d = ref_div(h.fn, h.a, h.b); e.dst = h.dst;
          e.rq = (h.b == 0) ? "R4" : "R3";
          mdq.push_back(e); div_end = cyc + 33;
        end
        default: ;
      endcase
      void'(prog.pop_front());
    end
    cyc++;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog (R1..R11 run): got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b1; in_class = 2'd2; in_func = 2'd0;
    in_opa = 32'd5; in_opb = 32'd1; in_dst = 5'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", {29'd0, alu_vld, md_vld, stall}, 32'd0);
    rst_n = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    chk("R10", {29'd0, alu_vld, md_vld, stall}, 32'd0);

    // R1: all arithmetic functions back to back
    add(0, 0, 32'd5, 32'd7, 1);
    add(0, 1, 32'd3, 32'd10, 2);
    add(0, 2, 32'hF0F0_1234, 32'h0FF0_FF00, 3);
    add(0, 3, 32'h8000_0001, 32'd1, 4);
    add(0, 3, 32'hDEAD_BEEF, 32'd32, 5);
    add(0, 3, 32'h1234_5678, 32'd31, 6);
    // R2 back-to-back multiplies, R8 with arithmetic completing alongside
    add(1, 0, 32'd3, 32'd5, 7);
    add(1, 3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8);
    add(0, 0, 32'd1, 32'd1, 9);
    add(0, 1, 32'd0, 32'd1, 10);
    add(1, 1, 32'h1234_5678, 32'h9ABC_DEF0, 11);
    // R6 divide right after a multiply, R7 arithmetic streams beside it
    add(1, 0, 32'd6, 32'd7, 12);
    add(2, 1, -32'sd100, 32'd7, 13);
    add(0, 0, 32'd100, 32'd1, 14);
    add(0, 2, 32'hFFFF, 32'h00FF, 15);
    add(3, 0, 32'd0, 32'd0, 16);
    add(0, 1, 32'd50, 32'd8, 17);
    // R5 multiply held behind the divide, then R6 divide after divide
    add(1, 0, 32'd11, 32'd13, 18);
    add(2, 0, 32'd100, 32'd7, 19);
    add(2, 2, 32'd100, 32'd7, 20);
    add(0, 0, 32'd2, 32'd2, 21);
    add(2, 3, -32'sd100, 32'd7, 22);
    add(2, 1, 32'd100, -32'sd7, 23);
    add(2, 1, 32'h8000_0000, 32'hFFFF_FFFF, 24);
    add(2, 0, 32'hFFFF_FFFF, 32'd2, 25);
    // R4 divide by zero, signed and unsigned, quotient and remainder
    add(2, 1, -32'sd9, 32'd0, 26);
    add(2, 3, -32'sd9, 32'd0, 27);
    add(2, 2, 32'd77, 32'd0, 28);
    add(0, 3, 32'h0000_0001, 32'd4, 29);
    while (prog.size() > 0) run_cycle();
    repeat (40) run_cycle();
    fin = 1'b1;
    summary();
    $finish;
  end
endmodule